// File: doc/BRIEF.md
# Read-Started ADC Register Front-End

This block is the register-side controller of a multiplexed sampling ADC. Software reaches it over a small 32-bit register bus. A read of the result register starts a new conversion and returns what the register held before the read. Software waits long enough for the conversion to finish, then reads again to collect the fresh sample. A ready flag in the top bit shows whether that sample is complete and new.

The analog input routing is held in a protected switch register. That register only accepts a write that comes on the access directly after a key write to a lock register. A divider pace selector, held in the same switch register, picks one of two clock divisors for conversion timing. Each change to the switch register starts a settling interval. During that interval the ready flag stays low, and any conversion that is requested waits until the interval ends.

The converter itself is a behavioural stand-in. It latches the signed `sample_in` value after a fixed number of divided clock ticks.

Top module: `adc_fe_top`

## Requirements
- R1: After reset the result register (offset 0x08) reads 0, the switch register (offset 0x18) reads 0, `mux_sel` is 0, and the slow divisor is selected.
- R2: A write to the switch register is ignored when the bus access just before it was not a write of 0xAA to the lock register (offset 0x20), so the switch register still reads back its old value.
- R3: A write of 0xAA to the lock register, followed directly by a switch-register write, loads bits [11:0] into the routing field and bit 16 into the fast-pace bit. Both read back, and the routing field drives `mux_sel`.
- R4: Unlocking is one-shot. Any access other than the switch write that follows it, including a read, relocks the switch register, and a lock write of any value other than 0xAA does not unlock it.
- R5: A read of the result register returns the contents held before that read (one cycle later, with `bus_rvalid` high) and clears the ready flag. An immediate second read therefore shows bit 31 low and the old sample in bits [15:0].
- R6: A conversion started by a result read completes after CONV_TICKS divided ticks. After that, a result read shows bit 31 set.
- R7: A result read made while a conversion is still running discards that conversion and restarts timing from the new read.
- R8: With the fast-pace bit set, the divisor is DIV_FAST. With it clear, the divisor is DIV_SLOW, so one conversion takes about DIV_SLOW/DIV_FAST times longer.
- R9: After a switch-register update, a conversion requested during settling starts only after SETTLE_SLOW or SETTLE_FAST divided ticks, chosen by the new pace bit.
- R10: A switch-register update clears the ready flag, and the flag stays low for the whole settling interval.
- R11: The result word carries the sample as 16-bit two's complement in bits [15:0], the ready flag in bit 31, and zeros in bits [30:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High in the cycle after a read access |
| sample_in | input | SAMPLE_W | Signed value the converter stub latches at completion |
| mux_sel | output | ROUTE_W | Current input routing code to the analog switch matrix |

## Verification
The bench builds the block with the default divisors of 16 and 4, but with CONV_TICKS reduced to 6 and settling reduced to 3 slow ticks and 2 fast ticks. A full settle-plus-convert sequence at either pace then fits within about two hundred cycles. These short windows let the bench probe timing from both sides. It reads before the earliest possible completion and after the latest one, whatever the phase of the free-running divider, and it covers discarded conversions and requests made during settling.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;
  localparam logic [7:0]  OFS_RESULT = 8'h08;
  localparam logic [7:0]  OFS_SWITCH = 8'h18;
  localparam logic [7:0]  OFS_LOCK   = 8'h20;
  localparam logic [31:0] UNLOCK_KEY = 32'h0000_00AA;
  localparam int          PACE_BIT   = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_CONV   = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_fe_tick_gen.sv
module adc_fe_tick_gen #(
  parameter int DIV_SLOW = 16,
  parameter int DIV_FAST = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fast,
  output logic tick
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW      = $clog2(DIV_MAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = fast ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= limit) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_fe_lock.sv
module adc_fe_lock #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              unlocked,
  output logic              sw_load
);
  import adc_fe_pkg::*;

  logic key_write;

  assign key_write = acc && we && (addr == ADDR_W'(OFS_LOCK)) && (wdata == UNLOCK_KEY);
  assign sw_load   = acc && we && (addr == ADDR_W'(OFS_SWITCH)) && unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
    end else if (acc) begin
      unlocked <= key_write;
    end
  end
endmodule

// File: rtl/adc_fe_seq.sv
module adc_fe_seq #(
  parameter int SAMPLE_W    = 16,
  parameter int CONV_TICKS  = 20,
  parameter int SETTLE_SLOW = 40,
  parameter int SETTLE_FAST = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                fast,
  input  logic                sw_load,
  input  logic                start,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic                ready,
  output logic [SAMPLE_W-1:0] result,
  output logic                settling,
  output logic                busy
);
  import adc_fe_pkg::*;

  localparam int T_MAX0 = (SETTLE_SLOW > SETTLE_FAST) ? SETTLE_SLOW : SETTLE_FAST;
  localparam int T_MAX  = (T_MAX0 > CONV_TICKS) ? T_MAX0 : CONV_TICKS;
  localparam int TW     = $clog2(T_MAX + 1);

  seq_state_t    st;
  logic [TW-1:0] tmr;
  logic          pend;
  logic [TW-1:0] settle_last;

  assign settle_last = fast ? TW'(SETTLE_FAST - 1) : TW'(SETTLE_SLOW - 1);
  assign settling    = (st == SEQ_SETTLE);
  assign busy        = (st == SEQ_CONV);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SEQ_IDLE;
      tmr    <= '0;
      pend   <= 1'b0;
      ready  <= 1'b0;
      result <= '0;
    end else if (sw_load) begin
      st    <= SEQ_SETTLE;
      tmr   <= '0;
      ready <= 1'b0;
      pend  <= pend | (st == SEQ_CONV);
    end else if (start) begin
      ready <= 1'b0;
      if (st == SEQ_SETTLE) begin
        pend <= 1'b1;
      end else begin
        st  <= SEQ_CONV;
        tmr <= '0;
      end
    end else if (tick) begin
      case (st)
        SEQ_SETTLE: begin
          if (tmr == settle_last) begin
            st   <= pend ? SEQ_CONV : SEQ_IDLE;
            pend <= 1'b0;
            tmr  <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        SEQ_CONV: begin
          if (tmr == TW'(CONV_TICKS - 1)) begin
            result <= sample_in;
            ready  <= 1'b1;
            st     <= SEQ_IDLE;
            tmr    <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: tmr <= '0;
      endcase
    end
  end
endmodule

// File: rtl/adc_fe_top.sv
module adc_fe_top #(
  parameter int ADDR_W      = 8,
  parameter int SAMPLE_W    = 16,
  parameter int ROUTE_W     = 12,
  parameter int DIV_SLOW    = 16,
  parameter int DIV_FAST    = 4,
  parameter int CONV_TICKS  = 20,
  parameter int SETTLE_SLOW = 40,
  parameter int SETTLE_FAST = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [SAMPLE_W-1:0] sample_in,
  output logic [ROUTE_W-1:0]  mux_sel
);
  import adc_fe_pkg::*;

  localparam int RES_PAD = 31 - SAMPLE_W;
  localparam int SW_PAD  = PACE_BIT - ROUTE_W;

  logic                unlocked;
  logic                sw_load;
  logic                fast_q;
  logic                tick;
  logic                start;
  logic                ready;
  logic                settling;
  logic                busy;
  logic [SAMPLE_W-1:0] result;

  assign start = bus_req && !bus_we && (bus_addr == ADDR_W'(OFS_RESULT));

  adc_fe_lock #(.ADDR_W(ADDR_W)) lock_i (
    .clk(clk), .rst(rst), .acc(bus_req), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .unlocked(unlocked), .sw_load(sw_load)
  );

  adc_fe_tick_gen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) tick_i (
    .clk(clk), .rst(rst), .fast(fast_q), .tick(tick)
  );

  adc_fe_seq #(
    .SAMPLE_W(SAMPLE_W), .CONV_TICKS(CONV_TICKS),
    .SETTLE_SLOW(SETTLE_SLOW), .SETTLE_FAST(SETTLE_FAST)
  ) seq_i (
    .clk(clk), .rst(rst), .tick(tick), .fast(fast_q), .sw_load(sw_load),
    .start(start), .sample_in(sample_in), .ready(ready), .result(result),
    .settling(settling), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_sel <= '0;
      fast_q  <= 1'b0;
    end else if (sw_load) begin
      mux_sel <= bus_wdata[ROUTE_W-1:0];
      fast_q  <= bus_wdata[PACE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we) begin
        if (bus_addr == ADDR_W'(OFS_RESULT)) begin
          bus_rdata <= {ready, {RES_PAD{1'b0}}, result};
        end else if (bus_addr == ADDR_W'(OFS_SWITCH)) begin
          bus_rdata <= {{(31 - PACE_BIT){1'b0}}, fast_q, {SW_PAD{1'b0}}, mux_sel};
        end else begin
          bus_rdata <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/adc_fe_checker.sv
module adc_fe_checker #(
  parameter int ADDR_W  = 8,
  parameter int ROUTE_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_req,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [31:0]        bus_wdata,
  input logic               bus_rvalid,
  input logic [ROUTE_W-1:0] mux_sel,
  input logic               unlocked,
  input logic               ready,
  input logic               settling,
  input logic               busy
);
  import adc_fe_pkg::*;

  logic rd_result;
  logic key_wr;
  logic sw_wr;

  assign rd_result = bus_req && !bus_we && (bus_addr == ADDR_W'(OFS_RESULT));
  assign key_wr    = bus_req && bus_we && (bus_addr == ADDR_W'(OFS_LOCK)) && (bus_wdata == UNLOCK_KEY);
  assign sw_wr     = bus_req && bus_we && (bus_addr == ADDR_W'(OFS_SWITCH));

  assert_ready_clear_R5: assert property (@(posedge clk) disable iff (rst)
    rd_result |=> !ready);

  assert_read_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> bus_rvalid);

  assert_switch_guard_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(mux_sel) |-> $past(sw_wr && unlocked));

  assert_one_shot_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !key_wr) |=> !unlocked);

  assert_settle_low_R10: assert property (@(posedge clk) disable iff (rst)
    settling |-> !ready);

  assert_done_from_conv_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(busy));
endmodule

bind adc_fe_top adc_fe_checker #(.ADDR_W(ADDR_W), .ROUTE_W(ROUTE_W)) chk_i (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .mux_sel(mux_sel),
  .unlocked(unlocked), .ready(ready), .settling(settling), .busy(busy)
);

// File: tb/adc_fe_top_tb_top.sv
module adc_fe_top_tb_top;
  localparam int ADDR_W = 8;
  localparam int SW     = 16;
  localparam int RW     = 12;

  localparam logic [7:0] A_RES  = 8'h08;
  localparam logic [7:0] A_SW   = 8'h18;
  localparam logic [7:0] A_LOCK = 8'h20;

  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{16'h61A8, 16'h9E58, 16'h0000,
                                         16'hFFFF, 16'h7FFF, 16'h8000};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_req = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_rvalid;
  logic [SW-1:0]     sample_in = '0;
  logic [RW-1:0]     mux_sel;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  adc_fe_top #(
    .ADDR_W(ADDR_W), .SAMPLE_W(SW), .ROUTE_W(RW), .DIV_SLOW(16), .DIV_FAST(4),
    .CONV_TICKS(6), .SETTLE_SLOW(3), .SETTLE_FAST(2)
  ) dut_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .sample_in(sample_in), .mux_sel(mux_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    d = bus_rdata;
    total++;
    if (bus_rvalid !== 1'b1) begin
      bad++;
      $display("FAIL R5 rvalid actual=%b expected=1", bus_rvalid);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    rdreg(A_RES, rd);  check("R1 result", rd, 32'h0);
    rdreg(A_SW, rd);   check("R1 switch", rd, 32'h0);
    check("R1 mux_sel", {20'h0, mux_sel}, 32'h0);
    idle(130);

    // R2 write without unlock is ignored
    wr(A_SW, 32'h608);
    rdreg(A_SW, rd);   check("R2 no unlock", rd, 32'h0);

    // R4 wrong key, and unlock consumed by an intervening read
    wr(A_LOCK, 32'h55);
    wr(A_SW, 32'h608);
    rdreg(A_SW, rd);   check("R4 wrong key", rd, 32'h0);
    wr(A_LOCK, 32'hAA);
    rdreg(A_SW, rd);
    wr(A_SW, 32'h608);
    rdreg(A_SW, rd);   check("R4 relocked by read", rd, 32'h0);

    // R3 proper unlock then write
    wr(A_LOCK, 32'hAA);
    wr(A_SW, 32'h680);
    rdreg(A_SW, rd);   check("R3 switch readback", rd, 32'h680);
    check("R3 mux_sel", {20'h0, mux_sel}, 32'h680);
    idle(100);

    // R6 / R11 vector walk
    for (int i = 0; i < NVEC; i++) begin
      sample_in = VEC[i];
      rdreg(A_RES, rd);
      idle(120);
      rdreg(A_RES, rd);
      check("R6 R11 sample word", rd, {1'b1, 15'h0, VEC[i]});
    end

    // R5 immediate second read: flag cleared, old sample kept
    rdreg(A_RES, rd);  check("R5 second read", rd, {1'b0, 15'h0, VEC[NVEC-1]});
    idle(130);

    // R6 lower bound: slow conversion not done early
    rdreg(A_RES, rd);
    idle(72);
    rdreg(A_RES, rd);  check("R6 not done early", {31'h0, rd[31]}, 32'h0);
    idle(130);

    // R7 restart discards running conversion
    sample_in = 16'h1234;
    rdreg(A_RES, rd);
    idle(40);
    rdreg(A_RES, rd);  check("R7 mid read", {31'h0, rd[31]}, 32'h0);
    idle(75);
    rdreg(A_RES, rd);  check("R7 discarded", {31'h0, rd[31]}, 32'h0);
    idle(120);
    rdreg(A_RES, rd);  check("R7 restarted done", rd, 32'h8000_1234);

    // R8 fast pace
    wr(A_LOCK, 32'hAA);
    wr(A_SW, 32'h1_0640);
    rdreg(A_SW, rd);   check("R8 pace bit readback", rd, 32'h1_0640);
    idle(60);
    rdreg(A_RES, rd);
    idle(32);
    rdreg(A_RES, rd);  check("R8 fast done", {31'h0, rd[31]}, 32'h1);

    // R8 slow pace not done in the same window
    wr(A_LOCK, 32'hAA);
    wr(A_SW, 32'h0620);
    idle(200);
    rdreg(A_RES, rd);
    idle(32);
    rdreg(A_RES, rd);  check("R8 slow not done", {31'h0, rd[31]}, 32'h0);
    idle(150);

    // R10 update clears a completed flag
    rdreg(A_RES, rd);
    idle(130);
    wr(A_LOCK, 32'hAA);
    wr(A_SW, 32'h0610);
    rdreg(A_RES, rd);  check("R10 flag cleared by update", {31'h0, rd[31]}, 32'h0);
    idle(200);

    // R9 request during settling waits for settle + conversion
    wr(A_LOCK, 32'hAA);
    wr(A_SW, 32'h0604);
    rdreg(A_RES, rd);
    idle(112);
    rdreg(A_RES, rd);  check("R9 not before settle+conv", {31'h0, rd[31]}, 32'h0);
    idle(200);
    wr(A_LOCK, 32'hAA);
    wr(A_SW, 32'h0602);
    rdreg(A_RES, rd);
    idle(175);
    rdreg(A_RES, rd);  check("R9 done after settle+conv", {31'h0, rd[31]}, 32'h1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule